// File: doc/BRIEF.md
# Timebase Clock Input Noise Filter

This block cleans up an external timebase clock pin before transition-detect logic sees it. The raw pin is first brought into the system clock domain through a chain of flip-flops. A programmable integrating filter then removes any disturbance that lasts fewer system clocks than a configured length. The block reports the filtered level, together with one-cycle strobes that mark each rising and each falling change of that level.

The filter has two sub-modes. In the restart sub-mode, any cycle in which the input agrees with the output throws away the progress made so far. In the up/down sub-mode, disagreeing cycles add to a count and agreeing cycles take it away again, so noise bursts separated by short gaps can still build up to a toggle. The sub-mode and the length come from ports that belong to this filter alone. They are separate from whatever configures the per-channel input filters.

When angle mode is on, a routing output carries this filter's level in place of the channel 0 filtered input. When angle mode is off, the routing output carries channel 0 unchanged.

Top module: `tbclk_filter`

## Requirements
- R1: After a clean step on `tb_raw`, `tb_level` takes the new value after exactly SYNC_STAGES + L rising clock edges, where L is the effective length (default SYNC_STAGES = 2).
- R2: If the synchronized input disagrees with `tb_level` for fewer than L consecutive cycles and then agrees again, `tb_level` does not change and no strobe fires.
- R3: A disagreement that lasts exactly L consecutive cycles toggles `tb_level`.
- R4: With `flt_mode` = 0 (restart), the count returns to zero on every agreeing cycle. Bursts shorter than L separated by one agreeing cycle never toggle the output.
- R5: With `flt_mode` = 1 (up/down), each agreeing cycle lowers the count by one and the count stops at zero. Interrupted bursts accumulate: with L = 4, three disagreeing cycles, one agreeing cycle and two more disagreeing cycles toggle the output. After a long agreement, three disagreeing cycles do not.
- R6: `flt_len` = 0 behaves like `flt_len` = 1, so the output follows the input after SYNC_STAGES + 1 edges.
- R7: `tb_rise` is high for exactly one cycle, in the cycle where `tb_level` first reads 1 after reading 0. `tb_fall` behaves the same way for a change from 1 to 0. The two strobes are never high together.
- R8: `ch0_sel` equals `tb_level` when `angle_en` = 1 and equals `ch0_filt` when `angle_en` = 0, with no clock delay.
- R9: While `rst_n` is low, and directly after it is released, `tb_level`, `tb_rise` and `tb_fall` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| tb_raw | input | 1 | Asynchronous timebase clock pin |
| flt_mode | input | 1 | Sub-mode: 0 restart, 1 up/down |
| flt_len | input | LEN_W | Filter length in system clocks (0 acts as 1) |
| angle_en | input | 1 | Angle mode enable for channel 0 routing |
| ch0_filt | input | 1 | Filtered channel 0 input from the channel filter |
| tb_level | output | 1 | Filtered timebase level |
| tb_rise | output | 1 | One-cycle strobe on a 0 to 1 change of tb_level |
| tb_fall | output | 1 | One-cycle strobe on a 1 to 0 change of tb_level |
| ch0_sel | output | 1 | Channel 0 input as seen by transition detect |

## Verification
The hardest behaviour to reach from the ports is the difference between the two sub-modes. The same interrupted noise burst must pass in up/down mode and be rejected in restart mode. Separately, the up/down counter must be seen to stop at zero rather than wrap. The bench reaches both by driving timed sequences of short low runs on `tb_raw`, split by single high cycles or by long high stretches. It then predicts, edge by edge, the cycle in which the output toggles or proves that it stays put. A wrapped counter would produce a spurious toggle a few cycles after a fresh short burst, and that is the place the saturation scenario watches.

// File: rtl/tbf_pkg.sv
package tbf_pkg;
   typedef enum logic {
      FM_RESTART = 1'b0,
      FM_UPDOWN  = 1'b1
   } fmode_e;
endpackage

// File: rtl/tbf_sync.sv
module tbf_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad
         $error("tbf_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [LAST:0] chain_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               chain_q[gi] <= 1'b0;
            end else if (gi == 0) begin
               chain_q[gi] <= d_async;
            end else begin
               chain_q[gi] <= chain_q[(gi == 0) ? 0 : gi - 1];
            end
         end
      end
   endgenerate

   assign q_sync = chain_q[LAST];
endmodule

// File: rtl/tbf_integrator.sv
module tbf_integrator
   import tbf_pkg::*;
#(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             s_in,
   input  fmode_e           mode,
   input  logic [LEN_W-1:0] len,
   output logic             level,
   output logic             rise,
   output logic             fall
);
   localparam int CW = LEN_W + 1;

   generate
      if (LEN_W < 1 || LEN_W > 24) begin : g_bad
         $error("tbf_integrator: LEN_W out of range 1..24");
      end
   endgenerate

   logic [LEN_W-1:0] cnt_q, cnt_d;
   logic [CW-1:0]    eff_len;
   logic [CW-1:0]    cnt_inc;
   logic             differ;
   logic             hit;

   assign eff_len = (len == '0) ? CW'(1) : {1'b0, len};
   assign cnt_inc = {1'b0, cnt_q} + CW'(1);
   assign differ  = (s_in != level);
   assign hit     = differ && (cnt_inc >= eff_len);

   always_comb begin
      cnt_d = cnt_q;
      if (differ) begin
         cnt_d = hit ? '0 : cnt_inc[LEN_W-1:0];
      end else if (mode == FM_RESTART) begin
         cnt_d = '0;
      end else if (cnt_q != '0) begin
         cnt_d = cnt_q - LEN_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         level <= 1'b0;
         rise  <= 1'b0;
         fall  <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         level <= hit ? ~level : level;
         rise  <= hit & ~level;
         fall  <= hit & level;
      end
   end

   // R2: the count never reaches the effective length
   a_r2_cnt_below_len: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, cnt_q} < eff_len) || $changed(len));

   // R4: restart sub-mode clears the count after an agreeing cycle
   a_r4_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == FM_RESTART && s_in == level) |=> (cnt_q == '0));

   // R5: up/down sub-mode holds at zero while agreeing
   a_r5_floor_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == FM_UPDOWN && s_in == level && cnt_q == '0) |=> (cnt_q == '0));

   // R5: up/down sub-mode steps down by one on an agreeing cycle
   a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == FM_UPDOWN && s_in == level && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - LEN_W'(1)));
endmodule

// File: rtl/tbf_route.sv
module tbf_route (
   input  logic angle_en,
   input  logic tb_level,
   input  logic ch0_filt,
   output logic ch0_sel
);
   always_comb begin
      if (angle_en) ch0_sel = tb_level;
      else          ch0_sel = ch0_filt;
   end
endmodule

// File: rtl/tbclk_filter.sv
module tbclk_filter
   import tbf_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int LEN_W       = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tb_raw,
   input  logic             flt_mode,
   input  logic [LEN_W-1:0] flt_len,
   input  logic             angle_en,
   input  logic             ch0_filt,
   output logic             tb_level,
   output logic             tb_rise,
   output logic             tb_fall,
   output logic             ch0_sel
);
   logic   s_q;
   fmode_e mode_e;

   assign mode_e = fmode_e'(flt_mode);

   tbf_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (tb_raw),
      .q_sync  (s_q)
   );

   tbf_integrator #(.LEN_W(LEN_W)) u_int (
      .clk   (clk),
      .rst_n (rst_n),
      .s_in  (s_q),
      .mode  (mode_e),
      .len   (flt_len),
      .level (tb_level),
      .rise  (tb_rise),
      .fall  (tb_fall)
   );

   tbf_route u_route (
      .angle_en (angle_en),
      .tb_level (tb_level),
      .ch0_filt (ch0_filt),
      .ch0_sel  (ch0_sel)
   );

   // R7: strobes are mutually exclusive
   a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(tb_rise && tb_fall));

   // R7: a rise strobe marks a fresh 0 to 1 change
   a_r7_rise_edge: assert property (@(posedge clk) disable iff (!rst_n)
      tb_rise |-> (tb_level && !$past(tb_level)));

   // R7: a fall strobe marks a fresh 1 to 0 change
   a_r7_fall_edge: assert property (@(posedge clk) disable iff (!rst_n)
      tb_fall |-> (!tb_level && $past(tb_level)));

   // R1: the level only moves together with a strobe
   a_r1_move_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (tb_level != $past(tb_level)) |-> (tb_rise || tb_fall));
endmodule

// File: tb/sim_tbclk_filter.sv
module sim_tbclk_filter;
   localparam int LW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tb_raw = 1'b0;
   logic          flt_mode = 1'b0;
   logic [LW-1:0] flt_len = LW'(4);
   logic          angle_en = 1'b0;
   logic          ch0_filt = 1'b0;
   logic          tb_level, tb_rise, tb_fall, ch0_sel;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tbclk_filter #(.SYNC_STAGES(2), .LEN_W(LW)) u0 (
      .clk(clk), .rst_n(rst_n), .tb_raw(tb_raw), .flt_mode(flt_mode),
      .flt_len(flt_len), .angle_en(angle_en), .ch0_filt(ch0_filt),
      .tb_level(tb_level), .tb_rise(tb_rise), .tb_fall(tb_fall), .ch0_sel(ch0_sel)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // hold for n cycles, watching that level stays put with no strobes
   task automatic hold(input int n, input logic exp, input string req);
      logic bad = 1'b0;
      logic seen = exp;
      for (int i = 0; i < n; i++) begin
         edges(1);
         if (tb_level !== exp || tb_rise || tb_fall) begin
            bad = 1'b1;
            seen = tb_level;
         end
      end
      n_run++;
      if (bad) begin
         n_fail++;
         $display("FAIL %s hold: actual level %b expected %b without strobes", req, seen, exp);
      end
   endtask

   task automatic t_reset();
      chk("R9", "level in reset", tb_level, 1'b0);
      chk("R9", "rise in reset", tb_rise, 1'b0);
      rst_n = 1'b1;
      edges(1);
      chk("R9", "level after reset", tb_level, 1'b0);
      chk("R9", "fall after reset", tb_fall, 1'b0);
   endtask

   task automatic t_step();
      flt_mode = 1'b0; flt_len = LW'(4);
      tb_raw = 1'b1;
      edges(5);
      chk("R1", "level one edge early", tb_level, 1'b0);
      edges(1);
      chk("R1", "level at edge 6", tb_level, 1'b1);
      chk("R7", "rise with change", tb_rise, 1'b1);
      chk("R7", "no fall on rise", tb_fall, 1'b0);
      edges(1);
      chk("R7", "rise one cycle only", tb_rise, 1'b0);
   endtask

   task automatic t_glitch();
      tb_raw = 1'b0; edges(3);
      tb_raw = 1'b1;
      hold(12, 1'b1, "R2");
   endtask

   task automatic t_interrupted(input logic md);
      flt_mode = md;
      hold(6, 1'b1, "R4");
      tb_raw = 1'b0; edges(3);
      tb_raw = 1'b1; edges(1);
      tb_raw = 1'b0; edges(3);
      tb_raw = 1'b1;
      if (md == 1'b0) begin
         hold(12, 1'b1, "R4");
      end else begin
         chk("R5", "level before accumulate", tb_level, 1'b1);
         edges(1);
         chk("R5", "accumulated toggle", tb_level, 1'b0);
         chk("R5", "fall strobe", tb_fall, 1'b1);
         edges(4);
         chk("R5", "not yet back", tb_level, 1'b0);
         edges(1);
         chk("R1", "back high", tb_level, 1'b1);
         chk("R7", "rise back", tb_rise, 1'b1);
      end
   endtask

   task automatic t_saturate();
      flt_mode = 1'b1;
      hold(4, 1'b1, "R5");
      tb_raw = 1'b0; edges(3);
      tb_raw = 1'b1;
      hold(10, 1'b1, "R5");
      tb_raw = 1'b0; edges(3);
      tb_raw = 1'b1;
      hold(14, 1'b1, "R5");
   endtask

   task automatic t_exact();
      flt_mode = 1'b0;
      tb_raw = 1'b0; edges(4);
      tb_raw = 1'b1;
      edges(1);
      chk("R3", "level before exact toggle", tb_level, 1'b1);
      edges(1);
      chk("R3", "exact-width pulse passes", tb_level, 1'b0);
      chk("R7", "fall on exact", tb_fall, 1'b1);
      edges(3);
      chk("R3", "still low", tb_level, 1'b0);
      edges(1);
      chk("R3", "recovered", tb_level, 1'b1);
   endtask

   task automatic t_len0();
      flt_len = LW'(0);
      tb_raw = 1'b0; edges(2);
      chk("R6", "len0 early", tb_level, 1'b1);
      edges(1);
      chk("R6", "len0 at edge 3", tb_level, 1'b0);
      flt_len = LW'(1);
      tb_raw = 1'b1; edges(2);
      chk("R6", "len1 early", tb_level, 1'b0);
      edges(1);
      chk("R6", "len1 at edge 3", tb_level, 1'b1);
      flt_len = LW'(4);
      hold(6, 1'b1, "R6");
   endtask

   task automatic t_route();
      angle_en = 1'b0; ch0_filt = 1'b0; #1;
      chk("R8", "channel path low", ch0_sel, 1'b0);
      ch0_filt = 1'b1; #1;
      chk("R8", "channel path high", ch0_sel, 1'b1);
      angle_en = 1'b1; ch0_filt = 1'b0; #1;
      chk("R8", "angle path level 1", ch0_sel, 1'b1);
      ch0_filt = 1'b1;
      tb_raw = 1'b0; edges(6);
      chk("R8", "angle path level 0", ch0_sel, 1'b0);
      angle_en = 1'b0; #1;
      chk("R8", "back to channel", ch0_sel, 1'b1);
   endtask

   initial begin
      edges(3);
      t_reset();
      t_step();
      t_glitch();
      t_interrupted(1'b0);
      t_interrupted(1'b1);
      t_saturate();
      t_exact();
      t_len0();
      t_route();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule